// File: doc/BRIEF.md
# 8-bit ALU with Status Flag Register

This block is the arithmetic datapath of a small 8-bit controller core together with the flag register that the arithmetic updates. A combinational unit takes a memory operand and an accumulator operand and produces an 8-bit result. That result covers addition and subtraction with or without carry, decimal adjust, the bitwise operations, rotates, increment, decrement and clear. A zero-detect output from the result drives skip-on-zero decisions in the sequencer.

The status register sits in the data space at address 0AH (parameter `STATUS_ADDR`). It can be written by a plain data move through the write port, or be the destination of the ALU operation itself. Ordinary writes only touch the four arithmetic flags. The power-down and time-out flags are controlled by dedicated hardware inputs. The status register is not saved on interrupts or calls; the software must save it itself.

Top module: `alu8_flags`

## Requirements
- R1: After reset the status byte is 00H. Bits 7 and 6 always read as 0. The layout is C=bit0, AC=bit1, Z=bit2, OV=bit3, PD=bit4, TO=bit5.
- R2: The op codes are ADD=0 and ADC=1, both computing a+b+cin, where cin is 0 for ADD and C for ADC. On the clock edge, C takes the carry out of bit 7, AC the carry out of bit 3, OV the signed overflow and Z the zero test of the result.
- R3: The op codes SUB=2 and SBC=3 compute a+~b+cin, where cin is 1 for SUB and C for SBC. C=1 means no borrow, and AC means no borrow out of bit 3. OV and Z are updated as for addition.
- R4: DAA (op 4) works on a. It adds 06H when AC=1 or the low nibble is above 9. It then adds 60H when C=1, when the high nibble of that sum is above 9, or when that sum carried out. C becomes 1 exactly when the 60H step was applied. Only C is updated.
- R5: AND=5, OR=6 and XOR=7 combine a and b. CPL=8 inverts a. These four update only Z.
- R6: The rotates are RL=9, RR=10, RLC=11 and RRC=12, all on a. RL and RR rotate within the byte and copy the bit shifted out into C. RLC and RRC rotate through C. Only C is updated.
- R7: INC=13 and DEC=14 compute a+1 and a-1. CLR=15 yields 00H. All three update only Z.
- R8: The output skip is 1 exactly when result is 00H, combinationally.
- R9: A write to `STATUS_ADDR` through the write port loads bits 3..0 from the data. The write port ignores bits 7..4, and writes to any other address do not change the status.
- R10: When exec and dst_status are both set, the ALU result is the data written to the status register. The flags that the operation updates take priority over that data. A CLR aimed at the status register therefore leaves the low four bits at 0100. An ALU write wins over the write port in the same cycle.
- R11: PD and TO change only through set_pd, set_to and clr_pdto. A set input takes priority over clr_pdto.
- R12: With exec low and no status write, bits 3..0 of the status keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exec | input | 1 | Apply the flag update of op this cycle |
| op | input | 4 | Operation code |
| a | input | 8 | Memory operand |
| b | input | 8 | Accumulator operand |
| dst_status | input | 1 | ALU result is written to the status register |
| wr_en | input | 1 | Data-move write strobe |
| wr_addr | input | 8 | Data-move write address |
| wr_data | input | 8 | Data-move write data |
| set_pd | input | 1 | Set the power-down flag |
| set_to | input | 1 | Set the time-out flag |
| clr_pdto | input | 1 | Clear the power-down and time-out flags |
| result | output | 8 | ALU result |
| status | output | 8 | Status register |
| skip | output | 1 | Result-is-zero indication |

## Verification
Some rules are checked by the assertions on every cycle:
- bits 7..6 of the status stay zero;
- PD and TO move only on their hardware inputs, with set over clear;
- the arithmetic flags hold when nothing writes them;
- the logic operations leave C alone;
- a CLR into the status register ends with Z set.

The flag values themselves can only be shown by the bench's directed scenarios. These cover the carry, half-carry and overflow values of addition and subtraction, the decimal-adjust corrections, the rotate bit paths, and the priority of flag updates over written data.

// File: rtl/alu8_flags.sv
module alu8_flags #(
  parameter logic [7:0] STATUS_ADDR = 8'h0A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       exec,
  input  logic [3:0] op,
  input  logic [7:0] a,
  input  logic [7:0] b,
  input  logic       dst_status,
  input  logic       wr_en,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       set_pd,
  input  logic       set_to,
  input  logic       clr_pdto,
  output logic [7:0] result,
  output logic [7:0] status,
  output logic       skip
);
  localparam logic [3:0] OP_ADD = 4'd0, OP_ADC = 4'd1, OP_SUB = 4'd2, OP_SBC = 4'd3,
                         OP_DAA = 4'd4, OP_AND = 4'd5, OP_OR  = 4'd6, OP_XOR = 4'd7,
                         OP_CPL = 4'd8, OP_RL  = 4'd9, OP_RR  = 4'd10, OP_RLC = 4'd11,
                         OP_RRC = 4'd12, OP_INC = 4'd13, OP_DEC = 4'd14, OP_CLR = 4'd15;

  logic [3:0] flg_q;
  logic       pd_q, to_q;
  logic [3:0] flg_new, flg_mask;
  logic [8:0] sum, tmp;
  logic [4:0] half;
  logic [7:0] opb;
  logic       cin, lo_adj, hi_adj;

  wire c_q  = flg_q[0];
  wire ac_q = flg_q[1];

  always_comb begin
    result   = a;
    flg_new  = 4'b0000;
    flg_mask = 4'b0000;
    sum      = 9'd0;
    half     = 5'd0;
    tmp      = 9'd0;
    lo_adj   = 1'b0;
    hi_adj   = 1'b0;
    opb      = b;
    cin      = 1'b0;
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
        if (op == OP_SUB || op == OP_SBC) opb = ~b;
        cin = (op == OP_ADC || op == OP_SBC) ? c_q : (op == OP_SUB);
        sum  = {1'b0, a} + {1'b0, opb} + {8'd0, cin};
        half = {1'b0, a[3:0]} + {1'b0, opb[3:0]} + {4'd0, cin};
        result = sum[7:0];
        flg_new[0] = sum[8];
        flg_new[1] = half[4];
        flg_new[3] = (a[7] == opb[7]) && (sum[7] != a[7]);
        flg_mask = 4'b1111;
      end
      OP_DAA: begin
        lo_adj = ac_q || (a[3:0] > 4'd9);
        tmp    = {1'b0, a} + (lo_adj ? 9'h006 : 9'h000);
        hi_adj = c_q || tmp[8] || (tmp[7:4] > 4'd9);
        result = tmp[7:0] + (hi_adj ? 8'h60 : 8'h00);
        flg_new[0] = hi_adj;
        flg_mask = 4'b0001;
      end
      OP_AND: begin result = a & b; flg_mask = 4'b0100; end
      OP_OR:  begin result = a | b; flg_mask = 4'b0100; end
      OP_XOR: begin result = a ^ b; flg_mask = 4'b0100; end
      OP_CPL: begin result = ~a;    flg_mask = 4'b0100; end
      OP_RL:  begin result = {a[6:0], a[7]}; flg_new[0] = a[7]; flg_mask = 4'b0001; end
      OP_RR:  begin result = {a[0], a[7:1]}; flg_new[0] = a[0]; flg_mask = 4'b0001; end
      OP_RLC: begin result = {a[6:0], c_q};  flg_new[0] = a[7]; flg_mask = 4'b0001; end
      OP_RRC: begin result = {c_q, a[7:1]};  flg_new[0] = a[0]; flg_mask = 4'b0001; end
      OP_INC: begin result = a + 8'd1; flg_mask = 4'b0100; end
      OP_DEC: begin result = a - 8'd1; flg_mask = 4'b0100; end
      default: begin result = 8'h00; flg_mask = 4'b0100; end
    endcase
    flg_new[2] = (result == 8'h00);
  end

  assign skip = (result == 8'h00);

  wire       alu_wr  = exec && dst_status;
  wire       port_wr = wr_en && (wr_addr == STATUS_ADDR);
  wire [3:0] wr_lo   = alu_wr ? result[3:0] : wr_data[3:0];
  wire [3:0] base    = (alu_wr || port_wr) ? wr_lo : flg_q;
  wire [3:0] flg_d   = exec ? ((base & ~flg_mask) | (flg_new & flg_mask)) : base;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flg_q <= 4'b0000;
      pd_q  <= 1'b0;
      to_q  <= 1'b0;
    end else begin
      flg_q <= flg_d;
      if (set_pd)        pd_q <= 1'b1;
      else if (clr_pdto) pd_q <= 1'b0;
      if (set_to)        to_q <= 1'b1;
      else if (clr_pdto) to_q <= 1'b0;
    end
  end

  assign status = {2'b00, to_q, pd_q, flg_q};
endmodule

module alu8_flags_chk #(
  parameter logic [7:0] STATUS_ADDR = 8'h0A
) (
  input logic       clk,
  input logic       rst_n,
  input logic       exec,
  input logic [3:0] op,
  input logic       dst_status,
  input logic       wr_en,
  input logic [7:0] wr_addr,
  input logic       set_pd,
  input logic       set_to,
  input logic       clr_pdto,
  input logic [7:0] status
);
  // R1
  top_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[7:6] == 2'b00);
  // R11
  pd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_pd && !clr_pdto) |=> status[4] == $past(status[4]));
  // R11
  to_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_to |=> status[5]);
  // R11
  pd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pdto && !set_pd) |=> !status[4]);
  // R12
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!exec && !(wr_en && wr_addr == STATUS_ADDR)) |=> status[3:0] == $past(status[3:0]));
  // R5
  logic_keeps_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && !dst_status && !(wr_en && wr_addr == STATUS_ADDR) && op >= 4'd5 && op <= 4'd8)
      |=> status[0] == $past(status[0]));
  // R10
  clr_status_z_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && dst_status && op == 4'd15) |=> status[3:0] == 4'b0100);
endmodule

bind alu8_flags alu8_flags_chk #(.STATUS_ADDR(STATUS_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .exec(exec), .op(op), .dst_status(dst_status),
  .wr_en(wr_en), .wr_addr(wr_addr), .set_pd(set_pd), .set_to(set_to),
  .clr_pdto(clr_pdto), .status(status));

// File: tb/alu8_flags_test.sv
module alu8_flags_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, exec = 1'b0, dst_status = 1'b0, wr_en = 1'b0;
  logic set_pd = 1'b0, set_to = 1'b0, clr_pdto = 1'b0;
  logic [3:0] op = 4'd0;
  logic [7:0] a = 8'd0, b = 8'd0, wr_addr = 8'd0, wr_data = 8'd0;
  logic [7:0] result, status;
  logic skip;
  int checks = 0, fails = 0;
  logic [7:0] exp_st = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu8_flags uut (.clk(clk), .rst_n(rst_n), .exec(exec), .op(op), .a(a), .b(b),
    .dst_status(dst_status), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .set_pd(set_pd), .set_to(set_to), .clr_pdto(clr_pdto),
    .result(result), .status(status), .skip(skip));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // returns {mask[3:0], flags[3:0], result[7:0]}
  function automatic logic [15:0] model(input logic [3:0] o, input logic [7:0] x,
                                         input logic [7:0] y, input logic [7:0] st);
    int r, c, ac, ov, t;
    logic [3:0] m;
    r = x; c = 0; ac = 0; ov = 0; m = 4'b0100;
    case (o)
      0, 1: begin
        t = (o == 1) ? int'(st[0]) : 0;
        r = x + y + t; c = r >> 8; ac = ((x % 16) + (y % 16) + t) >= 16;
        r = r % 256; ov = (x[7] == y[7]) && (r / 128 != x[7]); m = 4'b1111;
      end
      2, 3: begin
        t = (o == 3) ? int'(st[0]) : 1;
        r = x + (255 - y) + t; c = r >> 8; ac = ((x % 16) + (15 - y % 16) + t) >= 16;
        r = r % 256; ov = (x[7] != y[7]) && (r / 128 != x[7]); m = 4'b1111;
      end
      4: begin
        r = x;
        if (st[1] || (x % 16) > 9) r = r + 6;
        if (st[0] || r > 255 || ((r % 256) / 16) > 9) begin r = r + 96; c = 1; end
        r = r % 256; m = 4'b0001;
      end
      5: r = x & y;
      6: r = x | y;
      7: r = x ^ y;
      8: r = 255 - x;
      9:  begin c = x[7]; r = (x * 2) % 256 + x[7]; m = 4'b0001; end
      10: begin c = x[0]; r = x / 2 + 128 * x[0]; m = 4'b0001; end
      11: begin c = x[7]; r = (x * 2) % 256 + st[0]; m = 4'b0001; end
      12: begin c = x[0]; r = x / 2 + 128 * st[0]; m = 4'b0001; end
      13: r = (x + 1) % 256;
      14: r = (x + 255) % 256;
      default: r = 0;
    endcase
    return {m, 1'(ov), 1'(r == 0), 1'(ac), 1'(c), 8'(r)};
  endfunction

  task automatic run_op(input string req, input logic [3:0] o, input logic [7:0] x,
                        input logic [7:0] y, input logic dst);
    logic [15:0] mv;
    logic [3:0] lo;
    @(negedge clk);
    op = o; a = x; b = y; dst_status = dst; exec = 1'b1;
    mv = model(o, x, y, exp_st);
    #1;
    check(req, result, mv[7:0]);
    check("R8", {7'd0, skip}, {7'd0, mv[7:0] == 8'h00});
    lo = dst ? mv[3:0] : exp_st[3:0];
    exp_st[3:0] = (lo & ~mv[15:12]) | (mv[11:8] & mv[15:12]);
    @(negedge clk);
    exec = 1'b0; dst_status = 1'b0;
    check(req, status, exp_st);
  endtask

  task automatic t_reset;
    check("R1", status, 8'h00);
  endtask

  task automatic t_add;
    run_op("R2", 4'd0, 8'h7F, 8'h01, 1'b0);
    run_op("R2", 4'd0, 8'hFF, 8'h01, 1'b0);
    run_op("R2", 4'd1, 8'h10, 8'h20, 1'b0);
    run_op("R2", 4'd0, 8'h80, 8'h80, 1'b0);
  endtask

  task automatic t_sub;
    run_op("R3", 4'd2, 8'h05, 8'h05, 1'b0);
    run_op("R3", 4'd2, 8'h03, 8'h05, 1'b0);
    run_op("R3", 4'd3, 8'h10, 8'h01, 1'b0);
    run_op("R3", 4'd2, 8'h80, 8'h01, 1'b0);
    run_op("R3", 4'd3, 8'h40, 8'h01, 1'b0);
  endtask

  task automatic t_daa;
    run_op("R2", 4'd0, 8'h38, 8'h45, 1'b0);
    run_op("R4", 4'd4, 8'h7D, 8'h00, 1'b0);
    run_op("R2", 4'd0, 8'h99, 8'h01, 1'b0);
    run_op("R4", 4'd4, 8'h9A, 8'h00, 1'b0);
    run_op("R2", 4'd0, 8'h09, 8'h09, 1'b0);
    run_op("R4", 4'd4, 8'h12, 8'h00, 1'b0);
  endtask

  task automatic t_logic;
    run_op("R5", 4'd5, 8'hF0, 8'h0F, 1'b0);
    run_op("R5", 4'd6, 8'hA0, 8'h05, 1'b0);
    run_op("R5", 4'd7, 8'h5A, 8'h5A, 1'b0);
    run_op("R5", 4'd8, 8'h3C, 8'h00, 1'b0);
  endtask

  task automatic t_rotate;
    run_op("R6", 4'd9,  8'h81, 8'h00, 1'b0);
    run_op("R6", 4'd10, 8'h02, 8'h00, 1'b0);
    run_op("R6", 4'd11, 8'h40, 8'h00, 1'b0);
    run_op("R6", 4'd9,  8'h80, 8'h00, 1'b0);
    run_op("R6", 4'd12, 8'h01, 8'h00, 1'b0);
    run_op("R6", 4'd12, 8'h02, 8'h00, 1'b0);
  endtask

  task automatic t_incdec;
    run_op("R7", 4'd13, 8'hFF, 8'h00, 1'b0);
    run_op("R7", 4'd14, 8'h01, 8'h00, 1'b0);
    run_op("R7", 4'd14, 8'h00, 8'h00, 1'b0);
    run_op("R7", 4'd15, 8'h55, 8'h00, 1'b0);
  endtask

  task automatic port_write(input string req, input logic [7:0] ad, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = ad; wr_data = d;
    if (ad == 8'h0A) exp_st[3:0] = d[3:0];
    @(negedge clk);
    wr_en = 1'b0;
    check(req, status, exp_st);
  endtask

  task automatic t_write;
    port_write("R9", 8'h0A, 8'hFF);
    port_write("R9", 8'h0B, 8'h00);
    port_write("R9", 8'h0A, 8'hF5);
  endtask

  task automatic t_dst;
    port_write("R10", 8'h0A, 8'h0B);
    run_op("R10", 4'd15, 8'h00, 8'h00, 1'b1);
    run_op("R10", 4'd5, 8'h0B, 8'h0F, 1'b1);
    run_op("R10", 4'd9, 8'h0C, 8'h00, 1'b1);
    @(negedge clk);
    op = 4'd13; a = 8'h07; exec = 1'b1; dst_status = 1'b1;
    wr_en = 1'b1; wr_addr = 8'h0A; wr_data = 8'h01;
    exp_st[3:0] = 4'b1000;
    @(negedge clk);
    exec = 1'b0; dst_status = 1'b0; wr_en = 1'b0;
    check("R10", status, exp_st);
  endtask

  task automatic t_pdto;
    port_write("R11", 8'h0A, 8'hFF);
    run_op("R11", 4'd15, 8'h00, 8'h00, 1'b1);
    @(negedge clk);
    set_pd = 1'b1;
    @(negedge clk);
    set_pd = 1'b0; exp_st[4] = 1'b1;
    check("R11", status, exp_st);
    @(negedge clk);
    set_to = 1'b1; clr_pdto = 1'b1;
    @(negedge clk);
    set_to = 1'b0; clr_pdto = 1'b0; exp_st[5] = 1'b1; exp_st[4] = 1'b0;
    check("R11", status, exp_st);
    port_write("R11", 8'h0A, 8'h00);
    run_op("R11", 4'd15, 8'h00, 8'h00, 1'b1);
    @(negedge clk);
    clr_pdto = 1'b1;
    @(negedge clk);
    clr_pdto = 1'b0; exp_st[5] = 1'b0;
    check("R11", status, exp_st);
  endtask

  task automatic t_idle;
    port_write("R12", 8'h0A, 8'h0A);
    @(negedge clk);
    op = 4'd0; a = 8'hFF; b = 8'hFF;
    repeat (3) @(negedge clk);
    check("R12", status, exp_st);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_add();
    t_sub();
    t_daa();
    t_logic();
    t_rotate();
    t_incdec();
    t_write();
    t_dst();
    t_pdto();
    t_idle();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule